// File: doc/BRIEF.md
# Gate Driver Power Mode Sequencer

This block sequences the power modes of a three-phase gate driver. It follows the supply through a held-reset phase, a power-up phase with the fault pin pulled low, a standby phase with the gate drivers off, an operating phase with the gate drivers and current-shunt amplifiers on, and a low-power sleep phase. Its inputs are two supply comparator flags, the enable-gate pin, a wake comparator, a fault flag and a register-write port. From these it drives the fault pin, the enables for the gate drivers, amplifiers, regulator and passive pulldowns, a charge-pump-ready flag and a strobe that clears the control registers.

A sleep request written over the register port is accepted only in standby with enable-gate low. Sleep is entered after a programmable delay. The only way out of sleep is the wake input, which re-runs power-up from the fault-low phase. Gate-driver shutdown on a fault, or on enable-gate going low, is combinational, so it takes effect in the same cycle. All other results follow the state register.

Top module: `gdrv_mode_seq`

## Requirements
- R1: While `logic_ok_i` is low, the block is held in its reset phase. In the same cycle all enables, `cp_ready_o` and `reg_clr_o` are 0 and `fault_n_o` is 1.
- R2: One cycle after `logic_ok_i` is sampled high in the reset phase, `fault_n_o` is 0, `vreg_en_o` and `pulldown_en_o` are 1, and `gate_en_o` is 0.
- R3: `fault_n_o` stays 0 until `uv2_ok_i` is sampled high. The next cycle the block is in standby with `fault_n_o` at 1.
- R4: In standby, `gate_en_o` and `amp_en_o` are 0, and `pulldown_en_o` and `vreg_en_o` are 1.
- R5: A rising edge of `en_gate_i` in standby with `fault_i` low moves the block to operating one cycle later. Operating sets `gate_en_o` and `amp_en_o` to 1 and `pulldown_en_o` to 0. If `en_gate_i` is already high on return to standby, the block does not enter operating until the pin goes low and then high again.
- R6: In operating, `fault_i` high or `en_gate_i` low clears `gate_en_o`, `amp_en_o` and `cp_ready_o` in the same cycle. The block is in standby from the next cycle.
- R7: `cp_ready_o` rises exactly SETTLE cycles after the clock edge that enters operating, where SETTLE = CLK_HZ/1000 (1 ms).
- R8: A write to address 9 with data bit 2 set requests sleep. The request is accepted only in standby with `en_gate_i` low. In any other state, or with `en_gate_i` high, it has no effect.
- R9: The delay field is bits 4:3 of address 11. Its code D gives a delay of D*TICK_CYC cycles. Sleep is entered D*TICK_CYC+1 cycles after the accepting write is sampled. In sleep, `vreg_en_o`, `gate_en_o` and `amp_en_o` are 0, `pulldown_en_o` is 1 and `fault_n_o` is 1.
- R10: In the first cycle of sleep, `reg_clr_o` pulses high for one cycle. The stored delay field is reset to 0 at the same time.
- R11: `wake_i` is honoured only in sleep and only while `uv2_ok_i` is high. In every other case it has no effect.
- R12: An accepted wake puts the block into the fault-low power-up phase one cycle later, with `vreg_en_o` at 1. Standby follows once `uv2_ok_i` is sampled high.
- R13: `uv2_ok_i` going low in standby, operating or the sleep delay returns the block to the fault-low power-up phase one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| logic_ok_i | input | 1 | Supply above the logic threshold |
| uv2_ok_i | input | 1 | Supply above undervoltage threshold 2 |
| en_gate_i | input | 1 | Enable-gate pin |
| wake_i | input | 1 | Wake comparator output |
| fault_i | input | 1 | Fault flag |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| fault_n_o | output | 1 | Active-low fault pin |
| gate_en_o | output | 1 | Gate-driver enable |
| amp_en_o | output | 1 | Current-shunt amplifier enable |
| vreg_en_o | output | 1 | Regulator enable |
| pulldown_en_o | output | 1 | Passive gate pulldown enable |
| cp_ready_o | output | 1 | Charge pump settled |
| reg_clr_o | output | 1 | Control-register clear strobe |

## Verification
Results that come from the state register appear one clock edge after the input that causes them is sampled. Gate and amplifier shutdown from a fault, from enable-gate going low, or from a logic-supply drop appears in the same cycle. The bench drives every input on the falling edge. It checks registered results at the next falling edge, and same-cycle results one time step after the drive. For the charge-pump flag and the sleep delay, the bench counts falling edges from the entry edge and checks the cycle just before the expected change and the cycle of the change: SETTLE for the flag, D*TICK_CYC+1 for sleep.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;
  typedef enum logic [2:0] {
    ST_RESET   = 3'd0,
    ST_PWRUP   = 3'd1,
    ST_STBY    = 3'd2,
    ST_OPER    = 3'd3,
    ST_SLPWAIT = 3'd4,
    ST_SLEEP   = 3'd5
  } gdrv_state_e;
endpackage

// File: rtl/gdrv_cfg_reg.sv
// Decodes the sleep request and holds the 2-bit sleep-delay selection.
module gdrv_cfg_reg #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 11,
  parameter int SLP_ADDR = 9,
  parameter int SLP_BIT  = 2,
  parameter int DLY_ADDR = 11,
  parameter int DLY_LSB  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              slp_req_o,
  output logic [1:0]        dly_sel_o
);
  localparam logic [ADDR_W-1:0] SLP_A = ADDR_W'(SLP_ADDR);
  localparam logic [ADDR_W-1:0] DLY_A = ADDR_W'(DLY_ADDR);

  logic [1:0] dly_q, dly_nx;
  logic       dly_ce;

  assign slp_req_o = wr_en_i && (wr_addr_i == SLP_A) && wr_data_i[SLP_BIT];

  always_comb begin
    dly_ce = 1'b0;
    dly_nx = dly_q;
    if (clr_i) begin
      dly_ce = 1'b1;
      dly_nx = 2'd0;
    end else if (wr_en_i && (wr_addr_i == DLY_A)) begin
      dly_ce = 1'b1;
      dly_nx = wr_data_i[DLY_LSB +: 2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dly_q <= 2'd0;
    else if (dly_ce) dly_q <= dly_nx;
  end

  assign dly_sel_o = dly_q;
endmodule

// File: rtl/gdrv_sleep_timer.sv
// Down-counter for the sleep-entry delay: loads sel*TICK_CYC, then counts to zero.
module gdrv_sleep_timer #(
  parameter int TICK_CYC = 100_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [1:0] sel_i,
  input  logic       run_i,
  output logic       done_o
);
  localparam int MAX_CYC = 3 * TICK_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_nx;
  logic          cnt_ce;

  always_comb begin
    cnt_ce = 1'b0;
    cnt_nx = cnt_q;
    if (load_i) begin
      cnt_ce = 1'b1;
      cnt_nx = CW'(sel_i) * CW'(TICK_CYC);
    end else if (run_i && (cnt_q != '0)) begin
      cnt_ce = 1'b1;
      cnt_nx = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_nx;
  end

  assign done_o = (cnt_q == '0);

  AST_DELAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !load_i && !done_o) |=> (cnt_q == $past(cnt_q) - CW'(1))); // R9
endmodule

// File: rtl/gdrv_settle_timer.sv
// Counts cycles spent in operating and raises the charge-pump-ready flag.
module gdrv_settle_timer #(
  parameter int SETTLE_CYC = 100_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic live_i,
  output logic ready_o
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYC);

  logic [CW-1:0] cnt_q, cnt_nx;
  logic          cnt_ce;

  always_comb begin
    cnt_ce = 1'b0;
    cnt_nx = cnt_q;
    if (!run_i) begin
      cnt_ce = (cnt_q != '0);
      cnt_nx = '0;
    end else if (cnt_q != LIMIT) begin
      cnt_ce = 1'b1;
      cnt_nx = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_nx;
  end

  assign ready_o = (cnt_q == LIMIT) && live_i;

  AST_READY_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(run_i)); // R7
endmodule

// File: rtl/gdrv_mode_fsm.sv
// Power-mode state machine with output decode and sleep-entry strobe.
module gdrv_mode_fsm
  import gdrv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        logic_ok_i,
  input  logic        uv2_ok_i,
  input  logic        en_gate_i,
  input  logic        fault_i,
  input  logic        wake_i,
  input  logic        slp_req_i,
  input  logic        dly_done_i,
  output gdrv_state_e state_o,
  output logic        slp_load_o,
  output logic        slp_enter_o,
  output logic        fault_n_o,
  output logic        gate_en_o,
  output logic        amp_en_o,
  output logic        vreg_en_o,
  output logic        pulldown_en_o,
  output logic        reg_clr_o
);
  gdrv_state_e state_q, state_nx;
  logic        en_prev_q;
  logic        clr_q;
  logic        en_rise;
  logic        oper_live;

  assign en_rise = en_gate_i && !en_prev_q;

  always_comb begin
    state_nx = state_q;
    if (!logic_ok_i) begin
      state_nx = ST_RESET;
    end else begin
      unique case (state_q)
        ST_RESET:   state_nx = ST_PWRUP;
        ST_PWRUP:   if (uv2_ok_i) state_nx = ST_STBY;
        ST_STBY: begin
          if (!uv2_ok_i)                    state_nx = ST_PWRUP;
          else if (slp_req_i && !en_gate_i) state_nx = ST_SLPWAIT;
          else if (en_rise && !fault_i)     state_nx = ST_OPER;
        end
        ST_OPER: begin
          if (!uv2_ok_i)                 state_nx = ST_PWRUP;
          else if (fault_i || !en_gate_i) state_nx = ST_STBY;
        end
        ST_SLPWAIT: begin
          if (!uv2_ok_i)       state_nx = ST_PWRUP;
          else if (dly_done_i) state_nx = ST_SLEEP;
        end
        ST_SLEEP:   if (wake_i && uv2_ok_i) state_nx = ST_PWRUP;
        default:    state_nx = ST_RESET;
      endcase
    end
  end

  assign slp_load_o  = (state_q == ST_STBY) && (state_nx == ST_SLPWAIT);
  assign slp_enter_o = (state_q == ST_SLPWAIT) && (state_nx == ST_SLEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_RESET;
      en_prev_q <= 1'b0;
      clr_q     <= 1'b0;
    end else begin
      state_q   <= state_nx;
      en_prev_q <= en_gate_i;
      clr_q     <= slp_enter_o;
    end
  end

  assign oper_live     = logic_ok_i && (state_q == ST_OPER) && en_gate_i && !fault_i;
  assign gate_en_o     = oper_live;
  assign amp_en_o      = oper_live;
  assign fault_n_o     = !(logic_ok_i && (state_q == ST_PWRUP));
  assign vreg_en_o     = logic_ok_i && (state_q inside {ST_PWRUP, ST_STBY, ST_OPER, ST_SLPWAIT});
  assign pulldown_en_o = logic_ok_i && (state_q != ST_RESET) && !oper_live;
  assign reg_clr_o     = logic_ok_i && clr_q;
  assign state_o       = state_q;

  AST_OPER_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OPER && logic_ok_i && uv2_ok_i && (fault_i || !en_gate_i))
      |=> (state_q == ST_STBY)); // R6
  AST_SLEEP_FROM_STBY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLPWAIT && $past(state_q) != ST_SLPWAIT)
      |-> ($past(state_q) == ST_STBY && !$past(en_gate_i))); // R8
  AST_CLR_ON_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && $past(state_q) != ST_SLEEP && logic_ok_i) |-> reg_clr_o); // R10
  AST_WAKE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_SLEEP && state_q != ST_SLEEP)
      |-> (state_q == ST_PWRUP || state_q == ST_RESET)); // R12
endmodule

// File: rtl/gdrv_mode_seq.sv
// Top level: reset synchronizer, mode FSM, configuration field and both timers.
module gdrv_mode_seq
  import gdrv_pkg::*;
#(
  parameter int CLK_HZ   = 100_000_000,
  parameter int TICK_CYC = 100_000,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 11,
  parameter int SLP_ADDR = 9,
  parameter int DLY_ADDR = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              logic_ok_i,
  input  logic              uv2_ok_i,
  input  logic              en_gate_i,
  input  logic              wake_i,
  input  logic              fault_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              fault_n_o,
  output logic              gate_en_o,
  output logic              amp_en_o,
  output logic              vreg_en_o,
  output logic              pulldown_en_o,
  output logic              cp_ready_o,
  output logic              reg_clr_o
);
  localparam int SETTLE_RAW = CLK_HZ / 1000;
  localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;

  logic [1:0]  rst_sync_q;
  logic        rst_n_int;
  gdrv_state_e state;
  logic        slp_req, slp_load, slp_enter, dly_done;
  logic [1:0]  dly_sel;
  logic        gate_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  gdrv_cfg_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLP_ADDR(SLP_ADDR), .SLP_BIT(2),
    .DLY_ADDR(DLY_ADDR), .DLY_LSB(3)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n_int),
    .clr_i(slp_enter || (state == ST_RESET)),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .slp_req_o(slp_req), .dly_sel_o(dly_sel)
  );

  gdrv_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n_int),
    .logic_ok_i(logic_ok_i), .uv2_ok_i(uv2_ok_i), .en_gate_i(en_gate_i),
    .fault_i(fault_i), .wake_i(wake_i), .slp_req_i(slp_req), .dly_done_i(dly_done),
    .state_o(state), .slp_load_o(slp_load), .slp_enter_o(slp_enter),
    .fault_n_o(fault_n_o), .gate_en_o(gate_live), .amp_en_o(amp_en_o),
    .vreg_en_o(vreg_en_o), .pulldown_en_o(pulldown_en_o), .reg_clr_o(reg_clr_o)
  );

  gdrv_sleep_timer #(.TICK_CYC(TICK_CYC)) u_slp (
    .clk(clk), .rst_n(rst_n_int), .load_i(slp_load), .sel_i(dly_sel),
    .run_i(state == ST_SLPWAIT), .done_o(dly_done)
  );

  gdrv_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n_int), .run_i(state == ST_OPER),
    .live_i(gate_live), .ready_o(cp_ready_o)
  );

  assign gate_en_o = gate_live;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n_int)
    !logic_ok_i |-> (!gate_en_o && !vreg_en_o && !pulldown_en_o && fault_n_o)); // R1
endmodule

// File: tb/gdrv_mode_seq_test.sv
module gdrv_mode_seq_test;
  localparam int CLK_HZ = 20_000;
  localparam int SETTLE = CLK_HZ / 1000;
  localparam int TICK   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic logic_ok = 1'b0, uv2_ok = 1'b0, en_gate = 1'b0, wake = 1'b0, fault = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [10:0] wr_data = '0;
  logic fault_n, gate_en, amp_en, vreg_en, pd_en, cp_ready, reg_clr;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  gdrv_mode_seq #(.CLK_HZ(CLK_HZ), .TICK_CYC(TICK)) uut (
    .clk(clk), .rst_n(rst_n), .logic_ok_i(logic_ok), .uv2_ok_i(uv2_ok),
    .en_gate_i(en_gate), .wake_i(wake), .fault_i(fault), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .fault_n_o(fault_n),
    .gate_en_o(gate_en), .amp_en_o(amp_en), .vreg_en_o(vreg_en),
    .pulldown_en_o(pd_en), .cp_ready_o(cp_ready), .reg_clr_o(reg_clr)
  );

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // expected order: fault_n gate amp vreg pulldown ready clr
  task automatic chk_all(input string req, input logic [6:0] exp);
    chk(req, "fault_n",  fault_n,  exp[6]);
    chk(req, "gate_en",  gate_en,  exp[5]);
    chk(req, "amp_en",   amp_en,   exp[4]);
    chk(req, "vreg_en",  vreg_en,  exp[3]);
    chk(req, "pulldown", pd_en,    exp[2]);
    chk(req, "cp_ready", cp_ready, exp[1]);
    chk(req, "reg_clr",  reg_clr,  exp[0]);
  endtask

  localparam logic [6:0] O_RESET = 7'b1000000;
  localparam logic [6:0] O_PWRUP = 7'b0001100;
  localparam logic [6:0] O_STBY  = 7'b1001100;
  localparam logic [6:0] O_OPER  = 7'b1111000;
  localparam logic [6:0] O_SLEEP = 7'b1000100;

  task automatic write(input logic [3:0] a, input logic [10:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset;
    step(3);
    chk_all("R1", O_RESET);
    rst_n = 1'b1;
    step(4);
    chk_all("R1", O_RESET);
  endtask

  task automatic t_powerup;
    logic_ok = 1'b1;
    step();
    chk_all("R2", O_PWRUP);
    step(3);
    chk_all("R3", O_PWRUP);
    uv2_ok = 1'b1;
    step();
    chk_all("R3", O_STBY);
    step(2);
    chk_all("R4", O_STBY);
  endtask

  task automatic t_operate;
    en_gate = 1'b1;
    step();
    chk_all("R5", O_OPER);
    step(SETTLE - 1);
    chk("R7", "cp_ready before settle", cp_ready, 1'b0);
    step();
    chk("R7", "cp_ready at settle", cp_ready, 1'b1);
  endtask

  task automatic t_fault;
    fault = 1'b1;
    #1;
    chk("R6", "gate_en same cycle", gate_en, 1'b0);
    chk("R6", "amp_en same cycle", amp_en, 1'b0);
    chk("R6", "cp_ready same cycle", cp_ready, 1'b0);
    step();
    chk_all("R6", O_STBY);
    fault = 1'b0;
    step(2);
    chk("R5", "no entry without edge", gate_en, 1'b0);
    write(4'd9, 11'h004);   // sleep request with enable-gate high
    step(4);
    chk("R8", "sleep refused while enable high", vreg_en, 1'b1);
    en_gate = 1'b0;
    step(TICK * 4);
    chk_all("R8", O_STBY);
    en_gate = 1'b1;
    step();
    chk_all("R5", O_OPER);
    en_gate = 1'b0;
    #1;
    chk("R6", "gate_en drop on enable low", gate_en, 1'b0);
    step();
    chk_all("R6", O_STBY);
  endtask

  task automatic t_sleep_in_oper;
    en_gate = 1'b1;
    step();
    write(4'd9, 11'h004);
    step(TICK * 4);
    chk("R8", "sleep ignored in operating", gate_en, 1'b1);
    chk("R8", "vreg kept in operating", vreg_en, 1'b1);
    en_gate = 1'b0;
    step(TICK * 4);
    chk_all("R8", O_STBY);
  endtask

  task automatic t_sleep_delay;
    write(4'd11, 11'(2 << 3));   // delay code 2
    write(4'd9, 11'h004);
    chk("R9", "vreg at accept", vreg_en, 1'b1);
    step(2 * TICK);
    chk("R9", "vreg just before sleep", vreg_en, 1'b1);
    chk("R10", "no clear before sleep", reg_clr, 1'b0);
    step();
    chk_all("R9", O_SLEEP | 7'b0000001);
    step();
    chk("R10", "clear is one pulse", reg_clr, 1'b0);
    chk_all("R9", O_SLEEP);
  endtask

  task automatic t_wake;
    uv2_ok = 1'b0;
    wake = 1'b1;
    step(3);
    chk_all("R11", O_SLEEP);
    uv2_ok = 1'b1;
    step();
    wake = 1'b0;
    chk_all("R12", O_PWRUP);
    step();
    chk_all("R12", O_STBY);
  endtask

  task automatic t_cleared_field;
    write(4'd9, 11'h004);   // delay field was cleared, so code 0
    chk("R10", "vreg at accept", vreg_en, 1'b1);
    step();
    chk_all("R10", O_SLEEP | 7'b0000001);
    wake = 1'b1;
    step();
    wake = 1'b0;
    step();
    chk_all("R12", O_STBY);
  endtask

  task automatic t_wake_ignored;
    wake = 1'b1;
    step(3);
    chk_all("R11", O_STBY);
    en_gate = 1'b1;
    step();
    step(2);
    chk_all("R11", O_OPER);
    wake = 1'b0;
  endtask

  task automatic t_uv2_drop;
    uv2_ok = 1'b0;
    step();
    chk_all("R13", O_PWRUP);
    uv2_ok = 1'b1;
    step();
    chk_all("R13", O_STBY);
    en_gate = 1'b0;
    step();
  endtask

  task automatic t_logic_drop;
    logic_ok = 1'b0;
    #1;
    chk_all("R1", O_RESET);
    step(2);
    chk_all("R1", O_RESET);
    logic_ok = 1'b1;
    step();
    chk_all("R2", O_PWRUP);
    step();
    chk_all("R3", O_STBY);
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_operate();
    t_fault();
    t_sleep_in_oper();
    t_sleep_delay();
    t_wake();
    t_cleared_field();
    t_wake_ignored();
    t_uv2_drop();
    t_logic_drop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule